// File: doc/BRIEF.md
# Accumulator ALU with Packed Status Flags

This block is the arithmetic core of a small 8-bit processor. It holds a working accumulator and combines it with an operand byte each cycle. The operation is chosen by a 4-bit code, and the block produces a byte result at once. On the next rising edge the block can store that result back into the accumulator and fold the operation's flags into a packed status byte. A separate unsigned 8x8 multiplier fills a 16-bit product register.

Two enables decide what each cycle commits. The surrounding core drives one enable for the accumulator write and one for the flag update. Fetch, instruction decode, data banking and the program counter are all outside this block. The result is combinational from the current accumulator and operand. Every stored register changes only on a clock edge.

The design is split into four parts: an adder/subtractor that also produces the nibble and signed side outputs, a logic unit, a multiplier, and a flag merger. The top module has one combinational process for operation decode and output selection, and one registered process for the accumulator, status and product registers.

Top module: `acc_alu`

## Requirements
- R1: When `rst` is high at a rising edge, the accumulator, status and product registers become zero at that edge.
- R2: The status byte has N at bit 4, OV at bit 3, Z at bit 2, DC at bit 1 and C at bit 0. Bits 7..5 always read zero.
- R3: Opcode 0 adds the operand to the accumulator. Opcode 1 also adds the stored C. On both, C takes the carry out of bit 7 and DC takes the carry out of bit 3.
- R4: For opcodes 0, 1 and 2, OV is set exactly when the two's-complement result overflows the signed byte range.
- R5: Opcode 2 computes accumulator minus operand. C is set when no borrow occurs out of bit 7, and DC is set when no borrow occurs out of the low nibble.
- R6: For every arithmetic and logic opcode, N copies bit 7 of the result, and Z is set when the result byte is zero.
- R7: Opcodes 3 (AND), 4 (OR), 5 (XOR), 6 (complement of the accumulator) and 8 (pass the operand) update only N and Z. They leave OV, DC and C as they were.
- R8: Opcode 7 writes the unsigned product of accumulator and operand into the product register at the edge, and gives the low product byte as the result. It changes no flag. No other opcode changes the product register.
- R9: With `acc_we` high, the accumulator takes the result at the edge. With `acc_we` low, the accumulator holds its value.
- R10: With `flag_we` low, the status byte holds its value whatever the opcode.
- R11: Opcodes 9 to 15 are no-ops: the result equals the accumulator, and no flag and no product bit changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| op_i | input | 4 | Operation code |
| opnd_i | input | 8 | Operand byte |
| acc_we | input | 1 | Store the result in the accumulator at the edge |
| flag_we | input | 1 | Update the status flags at the edge |
| result_o | output | 8 | Combinational result of the current operation |
| acc_o | output | 8 | Accumulator contents |
| status_o | output | 8 | Packed status byte |
| prod_o | output | 16 | Product register |

## Verification
The bench builds the block only with its default 8-bit data width and 4-bit nibble. At that size every carry boundary can be reached with hand-picked bytes: 0x0F+0x01 for the nibble, 0xFF+0x01 for the byte, 0x7F+0x01 and 0x80-0x01 for the signed limits. The width also keeps the full 0xFF*0xFF product inside a 16-bit register, so the largest product can be checked exactly.

Before each vector, a preparation step puts C, DC and OV into a known state. This lets the checks on logic opcodes tell a preserved flag apart from a cleared one. It also lets the add-with-carry checks use a known incoming carry.

// File: rtl/alu_pkg.sv
package alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_ADC = 4'd1,
        OP_SUB = 4'd2,
        OP_AND = 4'd3,
        OP_IOR = 4'd4,
        OP_XOR = 4'd5,
        OP_CPL = 4'd6,
        OP_MUL = 4'd7,
        OP_MOV = 4'd8
    } op_e;

    typedef enum logic [1:0] {
        CLS_ARITH = 2'd0,
        CLS_LOGIC = 2'd1,
        CLS_NONE  = 2'd2
    } cls_e;

    localparam int FLAG_N  = 4;
    localparam int FLAG_OV = 3;
    localparam int FLAG_Z  = 2;
    localparam int FLAG_DC = 1;
    localparam int FLAG_C  = 0;
    localparam int NFLAGS  = 5;

endpackage

// File: rtl/alu_arith.sv
module alu_arith #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         half_c,
    output logic         ovf
);
    localparam int H  = W / 2;
    localparam int HU = W - H;

    logic [W-1:0] bx;
    logic         c0;
    logic [H:0]   lo_s;
    logic [HU:0]  hi_s;

    always_comb begin
        bx   = sub ? ~b : b;
        c0   = sub ? 1'b1 : cin;
        lo_s = {1'b0, a[H-1:0]} + {1'b0, bx[H-1:0]} + {{H{1'b0}}, c0};
        hi_s = {1'b0, a[W-1:H]} + {1'b0, bx[W-1:H]} + {{HU{1'b0}}, lo_s[H]};
        sum    = {hi_s[HU-1:0], lo_s[H-1:0]};
        cout   = hi_s[HU];
        half_c = lo_s[H];
        ovf    = (a[W-1] == bx[W-1]) && (sum[W-1] != a[W-1]);
    end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [3:0]   op,
    output logic [W-1:0] y
);
    always_comb begin
        unique case (op)
            OP_AND:  y = a & b;
            OP_IOR:  y = a | b;
            OP_XOR:  y = a ^ b;
            OP_CPL:  y = ~a;
            OP_MOV:  y = b;
            default: y = a;
        endcase
    end
endmodule

// File: rtl/alu_mul.sv
module alu_mul #(
    parameter int W = 8
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] p
);
    localparam int PW = 2 * W;

    always_comb begin
        p = PW'(a) * PW'(b);
    end
endmodule

// File: rtl/alu_flags.sv
module alu_flags
    import alu_pkg::*;
#(
    parameter int W = 8
) (
    input  cls_e              cls,
    input  logic [W-1:0]      y,
    input  logic              cout,
    input  logic              half_c,
    input  logic              ovf,
    input  logic [NFLAGS-1:0] old_f,
    output logic [NFLAGS-1:0] new_f
);
    always_comb begin
        new_f = old_f;
        unique case (cls)
            CLS_ARITH: begin
                new_f[FLAG_N]  = y[W-1];
                new_f[FLAG_Z]  = (y == '0);
                new_f[FLAG_C]  = cout;
                new_f[FLAG_DC] = half_c;
                new_f[FLAG_OV] = ovf;
            end
            CLS_LOGIC: begin
                new_f[FLAG_N]  = y[W-1];
                new_f[FLAG_Z]  = (y == '0);
            end
            default: new_f = old_f;
        endcase
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [3:0]     op_i,
    input  logic [W-1:0]   opnd_i,
    input  logic           acc_we,
    input  logic           flag_we,
    output logic [W-1:0]   result_o,
    output logic [W-1:0]   acc_o,
    output logic [7:0]     status_o,
    output logic [2*W-1:0] prod_o
);
    localparam int PW = 2 * W;
    localparam int SPARE = 8 - NFLAGS;

    logic [W-1:0]      acc_q;
    logic [NFLAGS-1:0] flag_q;
    logic [PW-1:0]     prod_q;

    cls_e              cls;
    logic              is_sub;
    logic              add_cin;
    logic              prod_we;
    logic [W-1:0]      ar_sum;
    logic              ar_cout;
    logic              ar_half;
    logic              ar_ovf;
    logic [W-1:0]      lg_y;
    logic [PW-1:0]     mul_p;
    logic [NFLAGS-1:0] flag_nx;

    alu_arith #(.W(W)) u_arith (
        .a(acc_q), .b(opnd_i), .cin(add_cin), .sub(is_sub),
        .sum(ar_sum), .cout(ar_cout), .half_c(ar_half), .ovf(ar_ovf)
    );

    alu_logic #(.W(W)) u_logic (
        .a(acc_q), .b(opnd_i), .op(op_i), .y(lg_y)
    );

    alu_mul #(.W(W)) u_mul (
        .a(acc_q), .b(opnd_i), .p(mul_p)
    );

    alu_flags #(.W(W)) u_flags (
        .cls(cls), .y(result_o), .cout(ar_cout), .half_c(ar_half),
        .ovf(ar_ovf), .old_f(flag_q), .new_f(flag_nx)
    );

    // decode and output selection
    always_comb begin
        is_sub  = 1'b0;
        add_cin = 1'b0;
        prod_we = 1'b0;
        cls     = CLS_NONE;
        result_o = acc_q;
        unique case (op_i)
            OP_ADD: begin
                cls = CLS_ARITH;
                result_o = ar_sum;
            end
            OP_ADC: begin
                cls = CLS_ARITH;
                add_cin = flag_q[FLAG_C];
                result_o = ar_sum;
            end
            OP_SUB: begin
                cls = CLS_ARITH;
                is_sub = 1'b1;
                result_o = ar_sum;
            end
            OP_AND, OP_IOR, OP_XOR, OP_CPL, OP_MOV: begin
                cls = CLS_LOGIC;
                result_o = lg_y;
            end
            OP_MUL: begin
                prod_we = 1'b1;
                result_o = mul_p[W-1:0];
            end
            default: begin
                cls = CLS_NONE;
                result_o = acc_q;
            end
        endcase
    end

    // register process
    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            flag_q <= '0;
            prod_q <= '0;
        end else begin
            if (acc_we)  acc_q  <= result_o;
            if (flag_we) flag_q <= flag_nx;
            if (prod_we) prod_q <= mul_p;
        end
    end

    assign acc_o    = acc_q;
    assign status_o = {{SPARE{1'b0}}, flag_q};
    assign prod_o   = prod_q;

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
    parameter int W = 8
) (
    input logic           clk,
    input logic           rst,
    input logic [3:0]     op_i,
    input logic [W-1:0]   opnd_i,
    input logic           acc_we,
    input logic           flag_we,
    input logic [W-1:0]   result_o,
    input logic [W-1:0]   acc_o,
    input logic [7:0]     status_o,
    input logic [2*W-1:0] prod_o
);
    localparam int PW = 2 * W;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (acc_o == '0 && status_o == 8'h00 && prod_o == '0));

    // R9
    acc_load_chk: assert property (@(posedge clk) disable iff (rst)
        acc_we |=> acc_o == $past(result_o));

    // R9
    acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !acc_we |=> $stable(acc_o));

    // R10
    flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !flag_we |=> $stable(status_o));

    // R7
    logic_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_we && (op_i inside {4'd3, 4'd4, 4'd5, 4'd6, 4'd8}))
        |=> (status_o[3] == $past(status_o[3]) && status_o[1:0] == $past(status_o[1:0])));

    // R6
    zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_we && op_i <= 4'd8 && op_i != 4'd7)
        |=> status_o[2] == ($past(result_o) == '0));

    // R6
    neg_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_we && op_i <= 4'd8 && op_i != 4'd7)
        |=> status_o[4] == $past(result_o[W-1]));

    // R8
    mul_prod_chk: assert property (@(posedge clk) disable iff (rst)
        op_i == 4'd7 |=> prod_o == PW'($past(acc_o)) * PW'($past(opnd_i)));

    // R8
    mul_flags_chk: assert property (@(posedge clk) disable iff (rst)
        op_i == 4'd7 |=> $stable(status_o));

    // R8
    prod_hold_chk: assert property (@(posedge clk) disable iff (rst)
        op_i != 4'd7 |=> $stable(prod_o));

    // R11
    reserved_flags_chk: assert property (@(posedge clk) disable iff (rst)
        op_i > 4'd8 |=> $stable(status_o));

endmodule

bind acc_alu acc_alu_chk #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .op_i(op_i), .opnd_i(opnd_i), .acc_we(acc_we),
    .flag_we(flag_we), .result_o(result_o), .acc_o(acc_o),
    .status_o(status_o), .prod_o(prod_o)
);

// File: tb/sim_acc_alu.sv
module sim_acc_alu;
    localparam int NV = 20;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  op_i;
    logic [7:0]  opnd_i;
    logic        acc_we;
    logic        flag_we;
    logic [7:0]  result_o;
    logic [7:0]  acc_o;
    logic [7:0]  status_o;
    logic [15:0] prod_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    acc_alu u0 (
        .clk(clk), .rst(rst), .op_i(op_i), .opnd_i(opnd_i), .acc_we(acc_we),
        .flag_we(flag_we), .result_o(result_o), .acc_o(acc_o),
        .status_o(status_o), .prod_o(prod_o)
    );

    // {op, acc, opnd, carry_in, result, status, product}
    localparam logic [52:0] VEC [NV] = '{
        {4'd0, 8'h12, 8'h34, 1'b0, 8'h46, 8'h00, 16'h0000}, // R3
        {4'd0, 8'h0F, 8'h01, 1'b0, 8'h10, 8'h02, 16'h0000}, // R3 nibble
        {4'd0, 8'h7F, 8'h01, 1'b0, 8'h80, 8'h1A, 16'h0000}, // R4
        {4'd0, 8'hFF, 8'h01, 1'b0, 8'h00, 8'h07, 16'h0000}, // R3
        {4'd0, 8'h80, 8'h80, 1'b0, 8'h00, 8'h0D, 16'h0000}, // R4
        {4'd1, 8'h10, 8'h20, 1'b1, 8'h31, 8'h00, 16'h0000}, // R3 adc
        {4'd1, 8'h0F, 8'h00, 1'b1, 8'h10, 8'h02, 16'h0000}, // R3 adc
        {4'd1, 8'h0F, 8'h00, 1'b0, 8'h0F, 8'h00, 16'h0000}, // R3 adc
        {4'd2, 8'h05, 8'h03, 1'b0, 8'h02, 8'h03, 16'h0000}, // R5
        {4'd2, 8'h03, 8'h05, 1'b0, 8'hFE, 8'h10, 16'h0000}, // R5
        {4'd2, 8'h10, 8'h01, 1'b0, 8'h0F, 8'h01, 16'h0000}, // R5
        {4'd2, 8'h80, 8'h01, 1'b0, 8'h7F, 8'h09, 16'h0000}, // R4 R5
        {4'd2, 8'h42, 8'h42, 1'b1, 8'h00, 8'h07, 16'h0000}, // R5
        {4'd3, 8'hF0, 8'h3C, 1'b1, 8'h30, 8'h03, 16'h0000}, // R7
        {4'd4, 8'h00, 8'h00, 1'b0, 8'h00, 8'h04, 16'h0000}, // R7
        {4'd5, 8'hAA, 8'h55, 1'b0, 8'hFF, 8'h10, 16'h0000}, // R7
        {4'd6, 8'h0F, 8'h77, 1'b1, 8'hF0, 8'h13, 16'h0000}, // R7
        {4'd8, 8'h00, 8'h80, 1'b0, 8'h80, 8'h10, 16'h0000}, // R7
        {4'd7, 8'h0F, 8'h11, 1'b1, 8'hFF, 8'h07, 16'h00FF}, // R8
        {4'd7, 8'hFF, 8'hFF, 1'b0, 8'h01, 8'h04, 16'hFE01}  // R8
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [3:0] op, input logic [7:0] b, input logic wa, input logic wf);
        @(negedge clk);
        op_i = op; opnd_i = b; acc_we = wa; flag_we = wf;
        @(posedge clk);
        #1;
    endtask

    // status after prep: carry=1 -> 0x07, carry=0 -> 0x04
    task automatic prep(input logic c, input logic [7:0] a);
        step(4'd8, c ? 8'hFF : 8'h00, 1'b1, 1'b1);
        step(4'd0, c ? 8'h01 : 8'h00, 1'b1, 1'b1);
        step(4'd8, a, 1'b1, 1'b0);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; op_i = 4'd0; opnd_i = 8'h00; acc_we = 1'b0; flag_we = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R1 acc after reset", {8'h00, acc_o}, 16'h0000);
        chk("R1 status after reset", {8'h00, status_o}, 16'h0000);
        chk("R1 prod after reset", prod_o, 16'h0000);

        for (int i = 0; i < NV; i++) begin
            logic [3:0]  v_op;
            logic [7:0]  v_a, v_b, v_res, v_st;
            logic        v_c;
            logic [15:0] v_p;
            {v_op, v_a, v_b, v_c, v_res, v_st, v_p} = VEC[i];
            prep(v_c, v_a);
            @(negedge clk);
            op_i = v_op; opnd_i = v_b; acc_we = 1'b1; flag_we = 1'b1;
            #1;
            chk($sformatf("R3-R8 vec%0d result", i), {8'h00, result_o}, {8'h00, v_res});
            @(posedge clk);
            #1;
            chk($sformatf("R9 vec%0d acc", i), {8'h00, acc_o}, {8'h00, v_res});
            chk($sformatf("R2 vec%0d status", i), {8'h00, status_o}, {8'h00, v_st});
            if (v_op == 4'd7)
                chk($sformatf("R8 vec%0d product", i), prod_o, v_p);
        end

        // R8: product holds across other opcodes (last was FE01)
        step(4'd0, 8'h05, 1'b1, 1'b1);
        chk("R8 product kept", prod_o, 16'hFE01);

        // R11: reserved opcode, status from prep carry=1 is 0x07
        prep(1'b1, 8'h5A);
        @(negedge clk);
        op_i = 4'd12; opnd_i = 8'h00; acc_we = 1'b1; flag_we = 1'b1;
        #1;
        chk("R11 reserved result", {8'h00, result_o}, 16'h005A);
        @(posedge clk); #1;
        chk("R11 reserved status", {8'h00, status_o}, 16'h0007);
        chk("R11 reserved acc", {8'h00, acc_o}, 16'h005A);
        chk("R11 reserved product", prod_o, 16'hFE01);

        // R9 / R10: enables low leave state untouched
        prep(1'b0, 8'h33);
        step(4'd0, 8'hFF, 1'b0, 1'b0);
        chk("R9 acc held", {8'h00, acc_o}, 16'h0033);
        chk("R10 status held", {8'h00, status_o}, 16'h0004);
        step(4'd2, 8'h33, 1'b0, 1'b0);
        chk("R10 status held sub", {8'h00, status_o}, 16'h0004);
        // flags only, acc held: 0x33-0x33 -> Z,C,DC = 0x07
        step(4'd2, 8'h33, 1'b0, 1'b1);
        chk("R10 flags written", {8'h00, status_o}, 16'h0007);
        chk("R9 acc unchanged", {8'h00, acc_o}, 16'h0033);

        // R1: mid-run synchronous reset
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk); #1;
        rst = 1'b0;
        chk("R1 acc cleared", {8'h00, acc_o}, 16'h0000);
        chk("R1 status cleared", {8'h00, status_o}, 16'h0000);
        chk("R1 prod cleared", prod_o, 16'h0000);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule